// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a supervisory timer that raises a system reset when software stops servicing it. An 8-bit control word holds a 6-bit period code, an active-low reset-request bit and an enable bit. While the timer is enabled, a fixed two-stage clock divider produces one step every `PRE_A * PRE_B` cycles, and each step lowers a down-counter by one. The default step is 3072 cycles, so the 64 period codes give timeouts from 3072 to 196,608 cycles. Software keeps the reset away by writing the control word again before the counter runs out. Each write reloads the counter and restarts the divider.

A hardware-activation input turns the timer on whatever the stored enable bit holds. Software then cannot stop it. When the counter expires, or when software requests a reset by writing a zero to the request bit, the reset output is held high for a fixed number of cycles. During that time the control word returns to its power-on value and the counter is reloaded from it.

Top module: `wdog_top`

## Requirements
- R1: After the synchronous reset, `rd_data` reads 8'hFE and `wdt_rst_o` is low. The layout is bit 0 enable, bit 1 reset-request (active low) and bits 7:2 the period code.
- R2: A write with bit 0 set and bit 1 set, accepted at clock edge W, raises `wdt_rst_o` at edge W + N*STEP, where STEP = PRE_A*PRE_B and N is the period code. A code of 0 counts as 64.
- R3: A refreshing write made before expiry restarts the full period from the edge at which it is accepted.
- R4: With bit 0 clear and `hw_force` low, the counter stands still and no reset is produced. A later enabling write starts a full period.
- R5: With `hw_force` high, `rd_data` bit 0 reads 1, and a write with bit 0 clear still times out as in R2.
- R6: A write with bit 1 clear while enabled (by bit 0 or by `hw_force`) raises `wdt_rst_o` one edge after the write is accepted. With the timer disabled, such a write does not raise the reset.
- R7: Each reset pulse lasts exactly RST_HOLD cycles (16 by default).
- R8: While the pulse is high, the control word returns to 8'hFE (bit 0 reads 1 when `hw_force` is high) and the counter is reloaded with code 63. If the timer is still enabled, the next expiry comes 63*STEP cycles after the pulse falls.
- R9: A write accepted in the same cycle as the final step wins, so no reset is raised. Writes made while the pulse is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_force | input | 1 | Hardware activation: keeps the timer enabled |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word: {period[5:0], req_n, enable} |
| rd_data | output | 8 | Control word readback, bit 0 shows the effective enable |
| wdt_rst_o | output | 1 | Reset request, high for RST_HOLD cycles |

## Verification
A refreshing write and the final countdown step can fall on the same clock edge. The bench provokes this by placing a write exactly N*STEP cycles after an arming write. It then judges the result from the reset output: the output must stay low, and a full new period must be counted from that edge. If expiry wins instead, the pulse would be seen at once. A second collision is a write landing inside a reset pulse. That write must leave the control word at its power-on value once the pulse ends.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int RELOAD_W = 6;
  localparam int CTRL_W   = RELOAD_W + 2;

  typedef struct packed {
    logic [RELOAD_W-1:0] period;
    logic                hold_n;
    logic                arm;
  } wd_ctrl_t;

  localparam wd_ctrl_t CTRL_RST = '{period: {RELOAD_W{1'b1}}, hold_n: 1'b1, arm: 1'b0};
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRE_A = 12,
  parameter int PRE_B = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic step_o
);
  localparam int AW = (PRE_A > 1) ? $clog2(PRE_A) : 1;
  localparam int BW = (PRE_B > 1) ? $clog2(PRE_B) : 1;

  logic [AW-1:0] a_q;
  logic [BW-1:0] b_q;
  logic          a_end, b_end;

  assign a_end  = (a_q == AW'(PRE_A - 1));
  assign b_end  = (b_q == BW'(PRE_B - 1));
  assign step_o = a_end && b_end;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_end ? '0 : a_q + AW'(1);
      if (a_end) b_q <= b_end ? '0 : b_q + BW'(1);
    end
  end

  generate
    if (PRE_A * PRE_B > 1) begin : g_gap
      p_step_gap_r2: assert property (@(posedge clk) disable iff (rst)
        step_o |=> !step_o);
    end
  endgenerate
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_force,
  input  logic              wr_accept,
  input  wd_ctrl_t          wr_data,
  input  logic              restore,
  output wd_ctrl_t          ctrl_o,
  output logic              active_o,
  output logic              sw_req_o,
  output logic [CTRL_W-1:0] rd_data_o
);
  wd_ctrl_t ctrl_q;
  logic     pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      pend_q <= 1'b0;
    end else begin
      pend_q <= wr_accept && !restore && !wr_data.hold_n && (wr_data.arm || hw_force);
      if (restore)        ctrl_q <= CTRL_RST;
      else if (wr_accept) ctrl_q <= wr_data;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign active_o  = ctrl_q.arm | hw_force;
  assign sw_req_o  = pend_q;
  assign rd_data_o = {ctrl_q.period, ctrl_q.hold_n, active_o};

  p_idle_write_r4: assert property (@(posedge clk) disable iff (rst)
    wr_accept && !restore && !wr_data.arm && !hw_force |=> !sw_req_o);
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int RST_HOLD = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                active,
  input  logic                step,
  input  logic                load,
  input  logic [RELOAD_W-1:0] load_val,
  input  logic                sw_req,
  output logic                busy_o,
  output logic                start_o,
  output logic [RELOAD_W:0]   cnt_o
);
  localparam int CW = RELOAD_W + 1;
  localparam int HW = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;

  function automatic logic [CW-1:0] decode(input logic [RELOAD_W-1:0] v);
    if (v == '0) return CW'(1) << RELOAD_W;
    return {1'b0, v};
  endfunction

  logic [CW-1:0] cnt_q;
  logic [HW-1:0] hold_q;
  logic          busy_q;
  logic          expire;

  assign expire  = active && step && (cnt_q == CW'(1)) && !load && !busy_q;
  assign start_o = !busy_q && (expire || sw_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= decode(CTRL_RST.period);
      hold_q <= '0;
      busy_q <= 1'b0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      hold_q <= HW'(RST_HOLD - 1);
      cnt_q  <= decode(CTRL_RST.period);
    end else if (busy_q) begin
      if (hold_q == '0) busy_q <= 1'b0;
      else              hold_q <= hold_q - HW'(1);
    end else if (load) begin
      cnt_q <= decode(load_val);
    end else if (active && step) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;

  p_cnt_live_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q != '0);
  p_pulse_hold_r7: assert property (@(posedge clk) disable iff (rst)
    busy_q && hold_q != '0 |=> busy_q);
  p_pulse_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(hold_q) == '0);
  p_sw_next_r6: assert property (@(posedge clk) disable iff (rst)
    sw_req && !busy_q |=> busy_q);
  p_disabled_r4: assert property (@(posedge clk) disable iff (rst)
    !active && !busy_q && !load && !sw_req |=> $stable(cnt_q) && !busy_q);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int PRE_A    = 12,
  parameter int PRE_B    = 256,
  parameter int RST_HOLD = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_force,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              wdt_rst_o
);
  wd_ctrl_t          wr_ctrl, ctrl;
  logic              wr_accept, active, sw_req, busy, start, step;
  logic [RELOAD_W:0] cnt;

  assign wr_ctrl   = wd_ctrl_t'(wr_data);
  assign wr_accept = wr_en && !busy;

  wdog_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .hw_force  (hw_force),
    .wr_accept (wr_accept),
    .wr_data   (wr_ctrl),
    .restore   (start),
    .ctrl_o    (ctrl),
    .active_o  (active),
    .sw_req_o  (sw_req),
    .rd_data_o (rd_data)
  );

  wdog_prescale #(.PRE_A(PRE_A), .PRE_B(PRE_B)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clr    (!active || busy || wr_accept || start),
    .step_o (step)
  );

  wdog_count #(.RST_HOLD(RST_HOLD)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .step     (step),
    .load     (wr_accept),
    .load_val (wr_ctrl.period),
    .sw_req   (sw_req),
    .busy_o   (busy),
    .start_o  (start),
    .cnt_o    (cnt)
  );

  assign wdt_rst_o = busy;

  p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    wr_accept && !sw_req |=> !wdt_rst_o);
  p_restore_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_rst_o) |-> rd_data[CTRL_W-1:1] == {ctrl.period, ctrl.hold_n} &&
                         rd_data[CTRL_W-1:1] == {RELOAD_W+1{1'b1}});
  p_hw_count_r5: assert property (@(posedge clk) disable iff (rst)
    hw_force && step && !busy && !wr_accept && !sw_req |=> (cnt != $past(cnt)) || wdt_rst_o);
endmodule

// File: tb/wdog_top_bench.sv
`timescale 1ns/1ps
module wdog_top_bench;
  localparam int PA = 3, PB = 4, STEP = PA * PB, HOLD = 16;

  logic       clk = 1'b0, rst = 1'b1, hw_force = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       wdt_rst_o;
  int         tests = 0, fails = 0;

  always #2 clk = ~clk;

  wdog_top #(.PRE_A(PA), .PRE_B(PB), .RST_HOLD(HOLD)) u_wdog_top (
    .clk(clk), .rst(rst), .hw_force(hw_force), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .wdt_rst_o(wdt_rst_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic measure(output int n, input int limit);
    n = 0;
    while (!wdt_rst_o && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic wait_pulse(output int len);
    len = 0;
    while (wdt_rst_o && len < 1000) begin len++; @(negedge clk); end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c, len, exp;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(rd_data == 8'hFE, "R1 rd_data", rd_data, 8'hFE);
    chk(wdt_rst_o == 1'b0, "R1 reset low", wdt_rst_o, 0);

    // R2 R7 R8 sweep of every period code
    for (int n = 0; n < 64; n++) begin
      do_write({n[5:0], 2'b11});
      measure(c, 2000);
      exp = (n == 0) ? 64 * STEP : n * STEP;
      chk(c == exp, "R2 timeout", c, exp);
      wait_pulse(len);
      chk(len == HOLD, "R7 pulse length", len, HOLD);
      chk(rd_data == 8'hFE, "R8 restored word", rd_data, 8'hFE);
    end

    // R3 refresh before expiry
    do_write({6'd5, 2'b11});
    idle(40);
    chk(wdt_rst_o == 1'b0, "R3 before refresh", wdt_rst_o, 0);
    do_write({6'd5, 2'b11});
    measure(c, 2000);
    chk(c == 5 * STEP, "R3 restarted period", c, 5 * STEP);
    wait_pulse(len);

    // R9 write on the final-step edge wins
    do_write({6'd2, 2'b11});
    idle(22);
    chk(wdt_rst_o == 1'b0, "R9 pre-collision", wdt_rst_o, 0);
    do_write({6'd2, 2'b11});
    chk(wdt_rst_o == 1'b0, "R9 collision no reset", wdt_rst_o, 0);
    measure(c, 2000);
    chk(c == 2 * STEP, "R9 new period after collision", c, 2 * STEP);
    // R9 write during pulse is ignored
    do_write({6'd5, 2'b11});
    wait_pulse(len);
    chk(rd_data == 8'hFE, "R9 pulse write ignored", rd_data, 8'hFE);

    // R4 disabled: no counting, then enabling starts full period
    do_write({6'd1, 2'b10});
    idle(100);
    chk(wdt_rst_o == 1'b0, "R4 disabled no reset", wdt_rst_o, 0);
    chk(rd_data == 8'h06, "R4 word held", rd_data, 8'h06);
    do_write({6'd1, 2'b11});
    measure(c, 2000);
    chk(c == STEP, "R4 enable full period", c, STEP);
    wait_pulse(len);

    // R6 software reset request
    do_write({6'd10, 2'b01});
    chk(wdt_rst_o == 1'b0, "R6 not yet", wdt_rst_o, 0);
    idle(1);
    chk(wdt_rst_o == 1'b1, "R6 next clock", wdt_rst_o, 1);
    wait_pulse(len);
    chk(len == HOLD, "R7 sw pulse length", len, HOLD);
    do_write({6'd10, 2'b00});
    idle(200);
    chk(wdt_rst_o == 1'b0, "R6 disabled request ignored", wdt_rst_o, 0);

    // R5 hardware activation
    @(negedge clk); hw_force = 1'b1;
    do_write({6'd1, 2'b10});
    chk(rd_data == 8'h07, "R5 enable forced", rd_data, 8'h07);
    measure(c, 2000);
    chk(c == STEP, "R5 timeout while forced", c, STEP);
    wait_pulse(len);
    chk(rd_data == 8'hFF, "R8 restored forced", rd_data, 8'hFF);
    measure(c, 2000);
    chk(c == 63 * STEP, "R8 next expiry from code 63", c, 63 * STEP);
    wait_pulse(len);
    @(negedge clk); hw_force = 1'b0;
    idle(2);
    chk(rd_data == 8'hFE, "R1 word after release", rd_data, 8'hFE);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule